// File: doc/BRIEF.md
# Cycle-Steal DMA Sequencer

This block moves data for several independent channels over one shared bus. Each channel holds a source address, a destination address, a unit count and a control word. Once a channel is switched on, the sequencer asks for the bus and moves one transfer unit at a time. A unit is one read from the source followed by one write of the same word to the destination. After every unit the block gives the bus up for one cycle so the processor can use it. Only then does it pick the next unit.

At each unit boundary a fixed-priority pick chooses among the armed channels. Channel 0 has the highest priority. A channel that loses the pick keeps its addresses and its remaining count, and it carries on once every higher channel has run dry. A strobe marks the bus cycles of a channel's last unit. The channel's enable flag drops on its own when the count runs out.

Software programs the channels through a one-word write port. The field code selects which register of the chosen channel is written.

Top module: `cs_dma_seq`

## Requirements
- R1: After a control write turns a channel's enable on, the channel's first read strobe is no earlier than the third cycle after that write. With `bus_gnt` already high and the sequencer idle, `bus_rd` is first high in the fourth cycle after the write edge.
- R2: Each unit is one cycle with `bus_rd` high and `bus_addr` set to the source address. The next cycle has `bus_wr` high, `bus_addr` set to the destination address, and `bus_wdata` equal to the word sampled from `bus_rdata` at the end of the read cycle. The two strobes are never high together.
- R3: The cycle after every write cycle has `bus_req`, `bus_rd` and `bus_wr` all low. When more work is pending and `bus_gnt` is high, the next read strobe comes in the cycle right after that free cycle.
- R4: At each unit boundary the armed channel with the lowest index takes the next unit. A lower-priority channel that is overtaken keeps its position and resumes with its next address after the higher channel has finished.
- R5: A channel runs exactly as many units as its count register holds. A control write that sets enable (bit 0) while the count is zero is ignored, and the enable flag stays 0.
- R6: After each unit the source and destination addresses each advance by the unit size in bytes (DW/8). Control bit 1 holds the source address fixed, and control bit 2 holds the destination address fixed.
- R7: `xfer_end` is high during the read and write cycles of a channel's last unit, and only then.
- R8: A channel's bit in `ch_en` reads 0 from the cycle right after the write cycle of its last unit.
- R9: A control write that clears enable while one of the channel's units is in its read cycle still lets that unit's write cycle complete. The channel then starts no further unit.
- R10: No read cycle begins unless `bus_gnt` was high at the edge that starts it. While work is waiting for the grant, `bus_req` stays high.
- R11: During and right after reset, `ch_en` is all zero and `bus_req`, `bus_rd`, `bus_wr` and `xfer_end` are low.

Field codes on `cfg_fld`: 0 is the source address, 1 the destination address, 2 the unit count, 3 the control word (bit 0 enable, bit 1 fixed source, bit 2 fixed destination).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | $clog2(NCH) | Channel selected by the write |
| cfg_fld | input | 2 | Field code of the write |
| cfg_wdata | input | AW | Write value |
| ch_en | output | NCH | Enable flag of each channel |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus may be used by the sequencer |
| bus_addr | output | AW | Address of the current bus cycle |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_rdata | input | DW | Data returned during a read cycle |
| bus_wdata | output | DW | Data driven during a write cycle |
| xfer_end | output | 1 | Marks the cycles of a channel's last unit |

## Verification
The hardest case to reach is a higher-priority channel becoming armed in the middle of a lower channel's run. Its arming delay has to expire just before a unit boundary, so the stimulus waits for the low channel's first write strobe and enables channel 0 in that same cycle. The bench then checks the full order of source addresses, which shows the takeover at the second boundary and the resumed low channel continuing at its next address. A similar timed control write lands in the cycle of a read strobe to show that a disable does not cut a unit short.

// File: rtl/dmaseq_pkg.sv
`timescale 1ns/1ps
package dmaseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_RD   = 3'd2,
    S_WR   = 3'd3,
    S_REL  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    FLD_SRC = 2'd0,
    FLD_DST = 2'd1,
    FLD_CNT = 2'd2,
    FLD_CTL = 2'd3
  } cfg_fld_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_SFIX = 1;
  localparam int CTL_DFIX = 2;

  // cycles a freshly enabled channel waits before it may be picked
  localparam int ARM_CYC  = 2;
endpackage

// File: rtl/dmaseq_chan.sv
`timescale 1ns/1ps
module dmaseq_chan
  import dmaseq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_sel,
  input  logic [1:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          unit_rd,
  input  logic          unit_done,
  output logic          en_o,
  output logic          ready_o,
  output logic          last_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);
  localparam int DLW = $clog2(ARM_CYC + 1);
  localparam logic [DLW-1:0] ARM_V = DLW'(ARM_CYC);

  logic          en_q, sfix_q, dfix_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DLW-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sfix_q <= 1'b0;
      dfix_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      dly_q  <= '0;
    end else begin
      if (dly_q != ARM_V) dly_q <= dly_q + 1'b1;
      if (cfg_sel) begin
        case (cfg_fld_e'(cfg_fld))
          FLD_SRC: src_q <= cfg_wdata;
          FLD_DST: dst_q <= cfg_wdata;
          FLD_CNT: cnt_q <= cfg_wdata[CW-1:0];
          default: begin
            sfix_q <= cfg_wdata[CTL_SFIX];
            dfix_q <= cfg_wdata[CTL_DFIX];
            if (!cfg_wdata[CTL_EN]) begin
              en_q <= 1'b0;
            end else if (!en_q && cnt_q != '0) begin
              en_q  <= 1'b1;
              dly_q <= '0;
            end
          end
        endcase
      end
      if (unit_done) begin
        if (!sfix_q) src_q <= src_q + AW'(STEP);
        if (!dfix_q) dst_q <= dst_q + AW'(STEP);
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) en_q <= 1'b0;
      end
    end
  end

  assign en_o    = en_q;
  assign ready_o = en_q && (dly_q == ARM_V) && (cnt_q != '0);
  assign last_o  = (cnt_q == CW'(1));
  assign src_o   = src_q;
  assign dst_o   = dst_q;

  // R1: no read strobe for this channel in the three cycles after enable
  assert_start_gap_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> ##1 !unit_rd ##1 !unit_rd ##1 !unit_rd);

  // R5: a unit only completes while count is non-zero
  assert_count_live_R5: assert property (@(posedge clk) disable iff (rst)
    unit_done |-> (cnt_q != '0));

  // R8: enable drops right after the last unit
  assert_en_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (unit_done && cnt_q == CW'(1)) |=> !en_q);
endmodule

// File: rtl/dmaseq_arb.sv
`timescale 1ns/1ps
module dmaseq_arb #(
  parameter int NCH = 3,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [IW-1:0]  idx
);
  logic lower_req;

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  always_comb begin
    lower_req = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (IW'(i) < idx && req[i]) lower_req = 1'b1;
    end
    if (any) begin
      assert_prio_pick_R4: assert (req[idx] && !lower_req)
        else $error("arbiter picked a channel that is not the lowest requester");
    end
  end
endmodule

// File: rtl/cs_dma_seq.sv
`timescale 1ns/1ps
module cs_dma_seq
  import dmaseq_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [1:0]             cfg_fld,
  input  logic [AW-1:0]          cfg_wdata,
  output logic [NCH-1:0]         ch_en,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic [AW-1:0]          bus_addr,
  output logic                   bus_rd,
  output logic                   bus_wr,
  input  logic [DW-1:0]          bus_rdata,
  output logic [DW-1:0]          bus_wdata,
  output logic                   xfer_end
);
  localparam int IW   = $clog2(NCH);
  localparam int STEP = DW / 8;

  seq_state_e    st_q, st_n;
  logic [IW-1:0] cur_q, cur_n;
  logic [NCH-1:0] ready_v, last_v;
  logic [AW-1:0] src_v [NCH];
  logic [AW-1:0] dst_v [NCH];
  logic          pick_any;
  logic [IW-1:0] pick_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dmaseq_chan #(.AW(AW), .CW(CW), .STEP(STEP)) i_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_sel   (cfg_we && cfg_ch == IW'(g)),
      .cfg_fld   (cfg_fld),
      .cfg_wdata (cfg_wdata),
      .unit_rd   (bus_rd && cur_q == IW'(g)),
      .unit_done (st_q == S_WR && cur_q == IW'(g)),
      .en_o      (ch_en[g]),
      .ready_o   (ready_v[g]),
      .last_o    (last_v[g]),
      .src_o     (src_v[g]),
      .dst_o     (dst_v[g])
    );
  end

  dmaseq_arb #(.NCH(NCH), .IW(IW)) i_arb (
    .req (ready_v),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    case (st_q)
      S_IDLE: if (pick_any) begin
        st_n  = S_REQ;
        cur_n = pick_idx;
      end
      S_REQ: if (!pick_any) begin
        st_n = S_IDLE;
      end else begin
        cur_n = pick_idx;
        if (bus_gnt) st_n = S_RD;
      end
      S_RD:  st_n = S_WR;
      S_WR:  st_n = S_REL;
      S_REL: if (!pick_any) begin
        st_n = S_IDLE;
      end else begin
        cur_n = pick_idx;
        st_n  = bus_gnt ? S_RD : S_REQ;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      bus_req   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      xfer_end  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cur_q   <= cur_n;
      bus_req <= st_n inside {S_REQ, S_RD, S_WR};
      bus_rd  <= (st_n == S_RD);
      bus_wr  <= (st_n == S_WR);
      if (st_n == S_RD)      bus_addr <= src_v[cur_n];
      else if (st_n == S_WR) bus_addr <= dst_v[cur_q];
      if (st_q == S_RD) bus_wdata <= bus_rdata;
      xfer_end <= (st_n == S_RD || st_n == S_WR) && last_v[cur_n];
    end
  end

  // R2: a read cycle is always followed by its write cycle
  assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_wr);

  // R2: the written word is the word read one cycle earlier
  assert_wr_data_R2: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_wdata == $past(bus_rdata)));

  // R2: strobes are exclusive
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr}));

  // R3: one free bus cycle after every write
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (!bus_req && !bus_rd && !bus_wr));

  // R10: a read only starts on an edge where the grant was present
  assert_gnt_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |-> $past(bus_gnt));

  // R7: end marker only rides on bus cycles
  assert_end_on_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> (bus_rd || bus_wr));
endmodule

// File: tb/test_cs_dma_seq.sv
`timescale 1ns/1ps
module test_cs_dma_seq;
  localparam int NCH = 3;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we;
  logic [1:0] cfg_ch;
  logic [1:0] cfg_fld;
  logic [AW-1:0] cfg_wdata;
  logic [NCH-1:0] ch_en;
  logic bus_req, bus_gnt, bus_rd, bus_wr, xfer_end;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_rdata, bus_wdata;

  always #5 clk = ~clk;

  cs_dma_seq #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) i_cs_dma_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .ch_en(ch_en), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .xfer_end(xfer_end)
  );

  assign bus_rdata = bus_addr ^ KEY;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor: one record per unit
  logic [AW-1:0] u_src [16];
  logic [AW-1:0] u_dst [16];
  logic [DW-1:0] u_wd  [16];
  int   u_rc [16];
  int   u_wc [16];
  logic u_re [16];
  logic u_we [16];
  int nu = 0;
  int nrd = 0;
  int rel_bad = 0;
  logic prev_wr = 1'b0;
  logic [NCH-1:0] prev_en = '0;
  int fall_cyc [NCH];

  always @(negedge clk) begin
    if (prev_wr && (bus_req || bus_rd || bus_wr)) rel_bad++;
    prev_wr = bus_wr;
    for (int c = 0; c < NCH; c++)
      if (prev_en[c] && !ch_en[c]) fall_cyc[c] = cyc;
    prev_en = ch_en;
    if (bus_rd) begin
      nrd++;
      if (nu < 16) begin
        u_src[nu] = bus_addr; u_rc[nu] = cyc; u_re[nu] = xfer_end;
      end
    end
    if (bus_wr) begin
      if (nu < 16) begin
        u_dst[nu] = bus_addr; u_wd[nu] = bus_wdata; u_wc[nu] = cyc; u_we[nu] = xfer_end;
      end
      nu++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic cfg(input int ch, input int fld, input int data);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_fld = 2'(fld); cfg_wdata = AW'(data);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic clr();
    nu = 0; nrd = 0; rel_bad = 0;
  endtask

  task automatic wait_off(input int ch);
    for (int i = 0; i < 300 && ch_en[ch]; i++) tick();
    repeat (4) tick();
  endtask

  task automatic t_reset();
    chk("R11 ch_en in reset", int'(ch_en), 0);
    chk("R11 strobes in reset", int'({bus_req, bus_rd, bus_wr, xfer_end}), 0);
    rst = 1'b0;
    tick();
    chk("R11 ch_en after reset", int'(ch_en), 0);
    chk("R11 strobes after reset", int'({bus_req, bus_rd, bus_wr, xfer_end}), 0);
  endtask

  task automatic t_single();
    int n;
    clr();
    cfg(1, 0, 'h0100); cfg(1, 1, 'h0200); cfg(1, 2, 3);
    cfg(1, 3, 1);
    n = 0;
    while (!bus_rd && n < 20) begin tick(); n++; end
    chk("R1 cycles from enable to first read", n, 4);
    wait_off(1);
    chk("R5 unit count", nu, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 read address", int'(u_src[i]), 'h0100 + 2*i);
      chk("R6 write address step", int'(u_dst[i]), 'h0200 + 2*i);
      chk("R2 write data", int'(u_wd[i]), int'(16'('h0100 + 2*i) ^ KEY));
      chk("R2 write follows read", u_wc[i], u_rc[i] + 1);
      if (i > 0) chk("R3 one free cycle between units", u_rc[i], u_wc[i-1] + 2);
      chk("R7 end marker on read", int'(u_re[i]), (i == 2) ? 1 : 0);
      chk("R7 end marker on write", int'(u_we[i]), (i == 2) ? 1 : 0);
    end
    chk("R3 bus idle after writes", rel_bad, 0);
    chk("R8 enable drop cycle", fall_cyc[1], u_wc[2] + 1);
    chk("R8 enable reads 0", int'(ch_en[1]), 0);
  endtask

  task automatic t_fixed();
    clr();
    cfg(2, 0, 'h0300); cfg(2, 1, 'h0400); cfg(2, 2, 2);
    cfg(2, 3, 3);
    wait_off(2);
    chk("R6 fixed source unit count", nu, 2);
    chk("R6 fixed source first", int'(u_src[0]), 'h0300);
    chk("R6 fixed source second", int'(u_src[1]), 'h0300);
    chk("R6 moving destination", int'(u_dst[1]), 'h0402);
    clr();
    cfg(0, 0, 'h0500); cfg(0, 1, 'h0600); cfg(0, 2, 2);
    cfg(0, 3, 5);
    wait_off(0);
    chk("R6 moving source", int'(u_src[1]), 'h0502);
    chk("R6 fixed destination first", int'(u_dst[0]), 'h0600);
    chk("R6 fixed destination second", int'(u_dst[1]), 'h0600);
  endtask

  task automatic t_prio();
    int exp_src [6] = '{'h0800, 'h0802, 'h0A00, 'h0A02, 'h0804, 'h0806};
    clr();
    cfg(2, 0, 'h0800); cfg(2, 1, 'h0900); cfg(2, 2, 4);
    cfg(0, 0, 'h0A00); cfg(0, 1, 'h0B00); cfg(0, 2, 2);
    cfg(2, 3, 1);
    for (int i = 0; i < 50 && nu < 1; i++) tick();
    cfg(0, 3, 1);
    wait_off(2);
    chk("R4 total units", nu, 6);
    for (int i = 0; i < 6; i++)
      chk("R4 unit order by source address", int'(u_src[i]), exp_src[i]);
    chk("R4 both channels finished", int'(ch_en), 0);
  endtask

  task automatic t_zero();
    clr();
    cfg(1, 2, 0);
    cfg(1, 3, 1);
    repeat (8) tick();
    chk("R5 zero count enable ignored", int'(ch_en[1]), 0);
    chk("R5 zero count no bus cycles", nrd, 0);
  endtask

  task automatic t_disable();
    clr();
    cfg(1, 0, 'h0C00); cfg(1, 1, 'h0D00); cfg(1, 2, 5);
    cfg(1, 3, 1);
    for (int i = 0; i < 20 && !bus_rd; i++) tick();
    cfg(1, 3, 0);
    repeat (10) tick();
    chk("R9 in-flight unit completes", nu, 1);
    chk("R9 write address of in-flight unit", int'(u_dst[0]), 'h0D00);
    chk("R9 no further reads", nrd, 1);
    chk("R9 enable off", int'(ch_en[1]), 0);
  endtask

  task automatic t_gnt();
    clr();
    bus_gnt = 1'b0;
    cfg(0, 0, 'h0E00); cfg(0, 1, 'h0F00); cfg(0, 2, 2);
    cfg(0, 3, 1);
    repeat (10) tick();
    chk("R10 no read without grant", nrd, 0);
    chk("R10 request held", int'(bus_req), 1);
    bus_gnt = 1'b1;
    for (int i = 0; i < 20 && nu < 1; i++) tick();
    bus_gnt = 1'b0;
    repeat (6) tick();
    chk("R10 second unit waits for grant", nu, 1);
    chk("R10 request raised again", int'(bus_req), 1);
    bus_gnt = 1'b1;
    wait_off(0);
    chk("R10 run completes after grant", nu, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_we = 1'b0; cfg_ch = '0; cfg_fld = '0; cfg_wdata = '0; bus_gnt = 1'b1;
    for (int c = 0; c < NCH; c++) fall_cyc[c] = -1;
    repeat (3) @(posedge clk);
    tick();
    t_reset();
    t_single();
    t_fixed();
    t_prio();
    t_zero();
    t_disable();
    t_gnt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule